// File: doc/BRIEF.md
# Fixed-Length Group Code Decoder

The block turns one fixed-length code word back into the ternary pixel codes of a single pixel group. Every group of a frame is stored with a code word of the same width, so the word for group g sits at bit offset g times the code width. A caller can therefore fetch any group by address and decode it alone. The decoder carries no state from one word to the next.

A code word has two fields. The class number sits in the upper bits and gives how many packed bytes of the group are nonzero. The entry index sits in the lower bits. Class zero means a group with no events, and it is decoded with no table access. For any other class the decoder reads one entry from an external synchronous table. The entry holds a position mask and the stored nonzero bytes. The bytes are scattered back to their positions. Each byte is then split into five base-3 digits by a five-stage divide-by-3 pipeline, and the padding digits past the group size are dropped.

Code words arrive on a valid/ready input and pixel groups leave on a valid/ready output. A transfer happens on a rising edge where valid and ready are both high. `in_ready` is high whenever the output register is empty or is being drained that cycle. The whole pipeline advances together, so while `out_valid` is high and `out_ready` is low, nothing moves and the output holds steady.

Top module: `gd_group_decoder`

## Requirements
- R1: An accepted code word is split into a class field, made of its upper $clog2(K+1) bits with K = ceil(GRP_PIX/5), and an index field, made of its lower IDX_W bits. A table read, when one is issued, presents exactly these two fields on `lut_rd_class` and `lut_rd_idx`.
- R2: A class-0 code word issues no table read and yields a group whose pixels are all 00, with `out_err` low.
- R3: If the class is above K, or the index is at or above the entry count of that class, no read is issued. The result is `out_err` high with all pixels 00. The count of class c (1..K) is `cls_count[(c-1)*(IDX_W+1) +: IDX_W+1]`. An index equal to count minus one is still legal.
- R4: A table entry has a K-bit position mask in bits [K-1:0], with stored byte j at bits [K+8j +: 8]. The j-th stored byte goes to the j-th set mask position, counting upward from position 0. Unmarked positions read as zero.
- R5: Packed byte k yields group symbols 5k..5k+4, least significant base-3 digit first. Digit 0 maps to pixel code 00, digit 1 to 01 and digit 2 to 10. Pixel p occupies `out_pix[2p+1:2p]`, in the group's row-major order, and code 11 never appears.
- R6: Only the first GRP_PIX symbols reach the output. Padding symbols of the last byte are dropped.
- R7: Table data is taken on `lut_rd_data` in the cycle after `lut_rd_en`, and is kept even if the pipeline stalls in that cycle. Results leave in the order the code words were accepted.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_pix` and `out_err` are held. After reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Code word valid |
| in_ready | output | 1 | Decoder can take a code word |
| in_code | input | CLS_W+IDX_W | Fixed-length group code word |
| cls_count | input | K*(IDX_W+1) | Entry count of each class 1..K |
| lut_rd_en | output | 1 | Table read request |
| lut_rd_class | output | CLS_W | Class table to read |
| lut_rd_idx | output | IDX_W | Entry to read |
| lut_rd_data | input | 9K | Entry returned one cycle after the request |
| out_valid | output | 1 | Decoded group valid |
| out_ready | input | 1 | Consumer takes the group |
| out_pix | output | 2*GRP_PIX | Pixel codes, pixel p at bits [2p+1:2p] |
| out_err | output | 1 | Code word was out of range |

## Verification
Some properties are checked on every cycle. Table reads carry the right fields, stay within the class counts and never happen for class 0. Error groups are blank, code 11 never appears, and the output holds under back-pressure. Other behaviour can only be shown by the scoreboard scenarios, which compare decoded pixels against a model built from powers of three. These cover the scatter order of stored bytes, dropping of the padding digit, the count boundary, in-order return of results, and keeping table data across a stall that falls right after a read.

// File: rtl/gd_pkg.sv
package gd_pkg;
  localparam int SYM_PER_BYTE = 5;
  localparam int BYTE_W       = 8;
  localparam int PIX_W        = 2;
  localparam int DIG_STAGES   = 5;

  function automatic int bytes_for(input int npix);
    return (npix + SYM_PER_BYTE - 1) / SYM_PER_BYTE;
  endfunction
endpackage

// File: rtl/gd_code_split.sv
module gd_code_split #(
  parameter int K    = 2,
  parameter int IB   = 4,
  parameter int CB   = 2,
  parameter int CNTW = IB + 1
) (
  input  logic [CB+IB-1:0] code_i,
  input  logic [K*CNTW-1:0] counts_i,
  output logic [CB-1:0]    cls_o,
  output logic [IB-1:0]    idx_o,
  output logic             zero_o,
  output logic             err_o
);
  logic [CNTW-1:0] cnt;
  logic            over;

  always_comb begin
    cls_o = code_i[CB+IB-1 -: CB];
    idx_o = code_i[IB-1:0];
    cnt   = '0;
    over  = 1'b1;
    for (int c = 1; c <= K; c++) begin
      if (cls_o == CB'(c)) begin
        cnt  = counts_i[(c-1)*CNTW +: CNTW];
        over = 1'b0;
      end
    end
    zero_o = (cls_o == '0);
    err_o  = !zero_o && (over || ({1'b0, idx_o} >= cnt));
  end
endmodule

// File: rtl/gd_scatter.sv
module gd_scatter #(
  parameter int K = 2
) (
  input  logic [9*K-1:0] entry_i,
  output logic [8*K-1:0] bytes_o
);
  always_comb begin
    int j;
    j = 0;
    bytes_o = '0;
    for (int k = 0; k < K; k++) begin
      if (entry_i[k]) begin
        bytes_o[k*8 +: 8] = entry_i[K + j*8 +: 8];
        j++;
      end
    end
  end
endmodule

// File: rtl/gd_b3_stage.sv
module gd_b3_stage #(
  parameter int K    = 2,
  parameter int NPIX = 9,
  parameter int STG  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              v_i,
  input  logic              e_i,
  input  logic [8*K-1:0]    q_i,
  input  logic [2*NPIX-1:0] s_i,
  output logic              v_o,
  output logic              e_o,
  output logic [8*K-1:0]    q_o,
  output logic [2*NPIX-1:0] s_o
);
  logic [8*K-1:0]    q_nxt;
  logic [2*NPIX-1:0] s_nxt;

  always_comb begin
    logic [7:0] a, nq;
    logic [1:0] r;
    q_nxt = '0;
    s_nxt = s_i;
    for (int k = 0; k < K; k++) begin
      a  = q_i[k*8 +: 8];
      nq = a / 8'd3;
      r  = 2'(a - 8'(nq * 8'd3));
      q_nxt[k*8 +: 8] = nq;
      if (k*5 + STG < NPIX) s_nxt[(k*5+STG)*2 +: 2] = r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      e_o <= 1'b0;
      q_o <= '0;
      s_o <= '0;
    end else if (adv) begin
      v_o <= v_i;
      e_o <= e_i;
      q_o <= q_nxt;
      s_o <= s_nxt;
    end
  end
endmodule

// File: rtl/gd_group_decoder.sv
module gd_group_decoder
  import gd_pkg::*;
#(
  parameter int GRP_PIX = 9,
  parameter int IDX_W   = 4,
  localparam int K      = bytes_for(GRP_PIX),
  localparam int CLS_W  = $clog2(K + 1),
  localparam int CODE_W = CLS_W + IDX_W,
  localparam int CNT_W  = IDX_W + 1,
  localparam int ENT_W  = K * (BYTE_W + 1),
  localparam int PIXB   = GRP_PIX * PIX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CODE_W-1:0]  in_code,
  input  logic [K*CNT_W-1:0] cls_count,
  output logic               lut_rd_en,
  output logic [CLS_W-1:0]   lut_rd_class,
  output logic [IDX_W-1:0]   lut_rd_idx,
  input  logic [ENT_W-1:0]   lut_rd_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIXB-1:0]    out_pix,
  output logic               out_err
);
  logic adv, accept, sp_zero, sp_err, kill;

  gd_code_split #(.K(K), .IB(IDX_W), .CB(CLS_W), .CNTW(CNT_W)) u_split (
    .code_i(in_code), .counts_i(cls_count),
    .cls_o(lut_rd_class), .idx_o(lut_rd_idx),
    .zero_o(sp_zero), .err_o(sp_err)
  );

  // Request stage: issue the table read, keep its answer across a stall
  logic             s1_v, s1_err, s1_kill, s1_fresh;
  logic [ENT_W-1:0] s1_hold, ent;
  logic [8*K-1:0]   scat;

  assign kill      = sp_zero | sp_err;
  assign accept    = in_valid & adv;
  assign lut_rd_en = accept & ~kill;
  assign in_ready  = adv;
  assign ent       = s1_fresh ? lut_rd_data : s1_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_err   <= 1'b0;
      s1_kill  <= 1'b1;
      s1_fresh <= 1'b0;
      s1_hold  <= '0;
    end else begin
      if (s1_fresh) s1_hold <= lut_rd_data;
      s1_fresh <= lut_rd_en;
      if (adv) begin
        s1_v    <= in_valid;
        s1_err  <= sp_err;
        s1_kill <= kill;
      end
    end
  end

  gd_scatter #(.K(K)) u_scatter (.entry_i(ent), .bytes_o(scat));

  // Scatter register feeding the digit pipeline
  logic            st0_v, st0_e;
  logic [8*K-1:0]  st0_q;
  logic [PIXB-1:0] st0_s;

  assign st0_s = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st0_v <= 1'b0;
      st0_e <= 1'b0;
      st0_q <= '0;
    end else if (adv) begin
      st0_v <= s1_v;
      st0_e <= s1_err;
      st0_q <= s1_kill ? '0 : scat;
    end
  end

  logic            st_v [1:DIG_STAGES];
  logic            st_e [1:DIG_STAGES];
  logic [8*K-1:0]  st_q [1:DIG_STAGES];
  logic [PIXB-1:0] st_s [1:DIG_STAGES];

  for (genvar g = 1; g <= DIG_STAGES; g++) begin : g_dig
    if (g == 1) begin : g_first
      gd_b3_stage #(.K(K), .NPIX(GRP_PIX), .STG(g-1)) u_stg (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .v_i(st0_v), .e_i(st0_e), .q_i(st0_q), .s_i(st0_s),
        .v_o(st_v[g]), .e_o(st_e[g]), .q_o(st_q[g]), .s_o(st_s[g])
      );
    end else begin : g_next
      gd_b3_stage #(.K(K), .NPIX(GRP_PIX), .STG(g-1)) u_stg (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .v_i(st_v[g-1]), .e_i(st_e[g-1]), .q_i(st_q[g-1]), .s_i(st_s[g-1]),
        .v_o(st_v[g]), .e_o(st_e[g]), .q_o(st_q[g]), .s_o(st_s[g])
      );
    end
  end

  assign out_valid = st_v[DIG_STAGES];
  assign out_err   = st_e[DIG_STAGES];
  assign out_pix   = st_s[DIG_STAGES];
  assign adv       = ~out_valid | out_ready;
endmodule

// File: rtl/gd_group_decoder_chk.sv
module gd_group_decoder_chk #(
  parameter int K      = 2,
  parameter int CLS_W  = 2,
  parameter int IDX_W  = 4,
  parameter int PIXB   = 18
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [CLS_W+IDX_W-1:0] in_code,
  input logic [K*(IDX_W+1)-1:0] cls_count,
  input logic                   lut_rd_en,
  input logic [CLS_W-1:0]       lut_rd_class,
  input logic [IDX_W-1:0]       lut_rd_idx,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [PIXB-1:0]        out_pix,
  input logic                   out_err
);
  logic [IDX_W:0] lim;
  logic           bad_code;

  always_comb begin
    lim = '0;
    for (int c = 1; c <= K; c++)
      if (lut_rd_class == CLS_W'(c)) lim = cls_count[(c-1)*(IDX_W+1) +: IDX_W+1];
    bad_code = 1'b0;
    for (int p = 0; p < PIXB/2; p++)
      if (out_pix[2*p +: 2] == 2'b11) bad_code = 1'b1;
  end

  AST_READ_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    lut_rd_en |-> (in_valid && in_ready && lut_rd_class == in_code[CLS_W+IDX_W-1 -: CLS_W]
                   && lut_rd_idx == in_code[IDX_W-1:0])); // R1
  AST_CLS0_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_code[CLS_W+IDX_W-1 -: CLS_W] == '0) |-> !lut_rd_en); // R2
  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lut_rd_en |-> ({1'b0, lut_rd_idx} < lim)); // R3
  AST_ERR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_pix == '0)); // R3
  AST_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !bad_code); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_err))); // R8
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
endmodule

bind gd_group_decoder gd_group_decoder_chk #(
  .K(K), .CLS_W(CLS_W), .IDX_W(IDX_W), .PIXB(PIXB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_code(in_code), .cls_count(cls_count), .lut_rd_en(lut_rd_en),
  .lut_rd_class(lut_rd_class), .lut_rd_idx(lut_rd_idx),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_err(out_err)
);

// File: tb/gd_group_decoder_tb.sv
`timescale 1ns/100ps
module gd_group_decoder_tb;
  localparam int NPIX = 9, IW = 4, K = 2, CW = 2, CODEW = 6, CNTW = 5;
  localparam int ENTW = 18, PIXB = 18;
  localparam int CNT1 = 5, CNT2 = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [CODEW-1:0] in_code = '0;
  logic [K*CNTW-1:0] cls_count;
  logic in_ready, lut_rd_en, out_valid, out_err;
  logic [CW-1:0] lut_rd_class;
  logic [IW-1:0] lut_rd_idx;
  logic [ENTW-1:0] lut_rd_data = '0;
  logic [PIXB-1:0] out_pix;

  always #2 clk = ~clk;
  assign cls_count = {5'(CNT2), 5'(CNT1)};

  gd_group_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .cls_count(cls_count), .lut_rd_en(lut_rd_en),
    .lut_rd_class(lut_rd_class), .lut_rd_idx(lut_rd_idx), .lut_rd_data(lut_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_err(out_err)
  );

  logic [ENTW-1:0] tbl [0:3][0:15];
  always @(posedge clk) if (lut_rd_en) lut_rd_data <= tbl[lut_rd_class][lut_rd_idx];

  int n_chk = 0, n_fail = 0;
  bit finished = 0, bp = 0;
  logic [PIXB:0] expq [$];
  string tagq [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [PIXB:0] model(input logic [CODEW-1:0] c);
    int cl, ix, j, pw;
    logic [7:0] by [0:K-1];
    logic [ENTW-1:0] e;
    logic [PIXB-1:0] pix;
    cl = int'(c[5:4]);
    ix = int'(c[3:0]);
    if (cl == 0) return '0;
    if (cl > K || ix >= (cl == 1 ? CNT1 : CNT2)) return {1'b1, {PIXB{1'b0}}};
    e = tbl[cl][ix];
    j = 0;
    for (int k = 0; k < K; k++) begin
      by[k] = 8'd0;
      if (e[k]) begin by[k] = e[K + 8*j +: 8]; j++; end
    end
    pix = '0;
    for (int p = 0; p < NPIX; p++) begin
      pw = 3 ** (p % 5);
      pix[2*p +: 2] = 2'((int'(by[p/5]) / pw) % 3);
    end
    return {1'b0, pix};
  endfunction

  task automatic send(input logic [CODEW-1:0] c, input string tag);
    logic [PIXB:0] ex;
    @(negedge clk); #0.8;
    in_valid = 1; in_code = c;
    #0.4;
    while (!in_ready) begin @(negedge clk); #1.2; end
    ex = model(c);
    if (c[5:4] == 2'd0)
      chk(!lut_rd_en, "R2", "class zero read", 32'(lut_rd_en), 0);
    else if (ex[PIXB])
      chk(!lut_rd_en, "R3", "out-of-range read", 32'(lut_rd_en), 0);
    else
      chk(lut_rd_en && lut_rd_class == c[5:4] && lut_rd_idx == c[3:0], "R1", "read fields",
          {lut_rd_en, 23'(lut_rd_class), lut_rd_idx}, {1'b1, 23'(c[5:4]), c[3:0]});
    expq.push_back(ex);
    tagq.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); #0.8; in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: sets ready at the falling edge, compares transfers due at the next rising edge
  initial begin
    logic [PIXB:0] ex, held;
    string tg;
    bit stalled = 0;
    forever begin
      @(negedge clk);
      out_ready = bp ? $urandom_range(0, 2) != 0 : 1'b1;
      #0.4;
      if (rst_n) begin
        if (stalled)
          chk(out_valid && {out_err, out_pix} == held, "R8", "held output",
              {out_valid, 12'b0, out_err, out_pix}, {1'b1, 12'b0, held});
        stalled = out_valid && !out_ready;
        held = {out_err, out_pix};
        if (out_valid && out_ready) begin
          if (expq.size() == 0) chk(0, "R7", "unexpected output", 32'(out_pix), 0);
          else begin
            ex = expq.pop_front();
            tg = tagq.pop_front();
            chk({out_err, out_pix} == ex, tg, "decoded group",
                32'({out_err, out_pix}), 32'(ex));
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "R7", "watchdog expired", 32'(expq.size()), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 16; i++) begin
        logic [7:0] b0, b1;
        b0 = 8'($urandom_range(1, 242));
        b1 = 8'($urandom_range(1, 242));
        tbl[c][i] = (c == 2) ? {b1, b0, 2'b11} : {8'd0, b0, (i % 2 == 0) ? 2'b01 : 2'b10};
      end
    tbl[1][0] = {8'd0, 8'd100, 2'b01};
    tbl[1][1] = {8'd0, 8'd242, 2'b10};
    tbl[2][0] = {8'd200, 8'd7, 2'b11};

    repeat (5) @(negedge clk);
    rst_n = 1;
    #0.6;
    chk(!out_valid && in_ready && !lut_rd_en, "R8", "reset state",
        {out_valid, in_ready, lut_rd_en}, 3'b010);

    send(6'b00_0101, "R2");   // class zero
    send(6'b01_0000, "R5");   // byte 100 at position 0
    send(6'b01_0001, "R6");   // byte 242 at position 1, fifth digit dropped
    send(6'b10_0000, "R4");   // two stored bytes in mask order
    send(6'b01_0100, "R3");   // last legal index of class 1
    send(6'b01_0101, "R3");   // index equal to count
    send(6'b11_0000, "R3");   // class beyond K
    send(6'b10_0010, "R4");
    send(6'b10_0011, "R3");
    idle(12);

    bp = 1;
    for (int n = 0; n < 300; n++) begin
      send(6'($urandom_range(0, 63)), "R7");
      if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 4));
    end
    idle(1);
    bp = 0;
    repeat (40) @(negedge clk);
    chk(expq.size() == 0, "R7", "all results returned", 32'(expq.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule